// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block connects a 32-bit integer core to a byte-addressed data memory. For each memory operation it forms the effective address from a base register value and a signed 16-bit displacement. It then issues a word-aligned memory request with per-byte enables. On stores it moves the source data into the byte lanes being written. On loads it takes the addressed byte or halfword out of the returned word and widens it to 32 bits, with either sign fill or zero fill.

The core offers one operation per cycle on `req_valid`. The registered memory request appears on the following cycle as a single-cycle `mem_req` pulse. Memory answers a read with `mem_rvalid` and `mem_rdata` one or more cycles later. Reads must come back in the order they were issued. The unit holds a small in-order queue that records the lane offset and width of each outstanding load, and returns each extended result one cycle after its read data arrives.

An access whose address does not suit its width is reported on `misalign` only. Such an access never reaches the memory and produces no load result. Memory is little-endian: the lowest byte lane holds the lowest address.

Top module: `lsu_align`

## Requirements
- R1: `req_op` encodes eight operations: 0 LB, 1 LH, 2 LW, 3 LBU, 4 LHU, 5 SB, 6 SH, 7 SW. The effective address EA is `req_base` plus `req_imm` sign-extended to 32 bits. On the cycle after an aligned request, `mem_req` is high for one cycle and `mem_addr` equals EA[31:2].
- R2: `mem_be` marks exactly the bytes being accessed. A byte access sets bit EA[1:0] only. A halfword access sets bits EA[1:0] and EA[1:0]+1. A word access sets all four bits. `mem_we` is high for SB/SH/SW and low for loads.
- R3: Store data is steered into lanes. SB repeats bits [7:0] of `req_wdata` in all four lanes. SH repeats bits [15:0] in both halves. SW passes the whole word unchanged.
- R4: LB returns byte lane EA[1:0] of the read word, and LH returns the halfword at lanes EA[1:0]+1 and EA[1:0]. In both cases every upper bit is a copy of the loaded value's top bit.
- R5: LBU and LHU select the same lanes as LB and LH, but fill every upper bit with zero.
- R6: LW returns the read word unchanged.
- R7: A halfword access with EA[0]=1, or a word access with EA[1:0]≠0, raises `misalign` for one cycle, on the cycle after the request. For that access `mem_req` stays low, so no write or read is issued and no load result follows.
- R8: `res_valid` pulses exactly one cycle after each `mem_rvalid`. Results come back in issue order for up to `CTX_DEPTH` outstanding loads, including loads issued on consecutive cycles.
- R9: While reset is low, and on the first cycle after reset is released, `mem_req`, `misalign` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | An operation is offered this cycle |
| req_op | input | 3 | Operation code (see R1) |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed displacement |
| req_wdata | input | 32 | Source register value for stores |
| misalign | output | 1 | Alignment fault for the previous cycle's request |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| res_valid | output | 1 | Load result valid |
| res_data | output | 32 | Extended load result |

## Verification
On every cycle the checker confirms several properties at the ports. Each memory request and each fault follows a request from the core. A fault never comes with a memory request. The byte-enable pattern always has a legal shape. Every result follows a read return. No read returns while the load queue is empty. Reset leaves the memory side and result side idle. Only the bench scenarios can show that the enables sit at the right offset, that data reaches the right lanes, that the right sign or zero fill is applied, and that pipelined loads come back in order. To cover these, the bench sweeps every operation over every byte offset of a 32-byte window, using base and displacement pairs of both signs. It compares each result against a byte-level shadow memory kept by the bench.

// File: rtl/lsu_align_pkg.sv
// Package: shared operation and access-size types for the load/store
// alignment unit. Assumes a 3-bit operation code as given in the brief.
package lsu_align_pkg;

    typedef enum logic [2:0] {
        OP_LB  = 3'd0,
        OP_LH  = 3'd1,
        OP_LW  = 3'd2,
        OP_LBU = 3'd3,
        OP_LHU = 3'd4,
        OP_SB  = 3'd5,
        OP_SH  = 3'd6,
        OP_SW  = 3'd7
    } lsu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } lsu_size_e;

    // Access width of an operation.
    function automatic lsu_size_e op_size(lsu_op_e op);
        case (op)
            OP_LB, OP_LBU, OP_SB: op_size = SZ_BYTE;
            OP_LH, OP_LHU, OP_SH: op_size = SZ_HALF;
            default:              op_size = SZ_WORD;
        endcase
    endfunction

    // True for the three write operations.
    function automatic logic op_is_store(lsu_op_e op);
        op_is_store = (op == OP_SB) || (op == OP_SH) || (op == OP_SW);
    endfunction

    // True for loads that fill upper bits with zero.
    function automatic logic op_zero_fill(lsu_op_e op);
        op_zero_fill = (op == OP_LBU) || (op == OP_LHU);
    endfunction

endpackage

// File: rtl/lsu_addr_decode.sv
// Module: forms the effective address, decodes the operation, derives the
// byte-enable mask and the alignment fault. Purely combinational.
// Assumes DATA_W is a multiple of 32 and IMM_W < DATA_W.
module lsu_addr_decode
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] ea_o,
    output lsu_size_e         size_o,
    output logic              zext_o,
    output logic              store_o,
    output logic              misalign_o,
    output logic [LANES-1:0]  be_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    lsu_op_e          op;
    logic [OFF_W-1:0] off;

    // Effective address: base plus sign-extended displacement.
    always_comb begin
        ea_o = base_i + {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end

    assign op  = lsu_op_e'(op_i);
    assign off = ea_o[OFF_W-1:0];

    // Operation attributes from the code.
    always_comb begin
        size_o  = op_size(op);
        zext_o  = op_zero_fill(op);
        store_o = op_is_store(op);
    end

    // Alignment fault: halfword on odd byte, word off a word boundary.
    always_comb begin
        case (size_o)
            SZ_HALF: misalign_o = off[0];
            SZ_WORD: misalign_o = |off;
            default: misalign_o = 1'b0;
        endcase
    end

    // Byte enables: a run of access-width lanes starting at the offset.
    always_comb begin
        int nbytes;
        case (size_o)
            SZ_BYTE: nbytes = 1;
            SZ_HALF: nbytes = 2;
            default: nbytes = LANES;
        endcase
        for (int i = 0; i < LANES; i++) begin
            be_o[i] = (i >= int'(off)) && (i < int'(off) + nbytes);
        end
    end

endmodule

// File: rtl/lsu_store_steer.sv
// Module: places store data into byte lanes by replication, so every lane
// a byte enable can select holds the right source byte. Combinational.
// Assumes byte and halfword stores take the low bits of the source.
module lsu_store_steer
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input  lsu_size_e         size_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] lanes_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane g: low byte, alternating halfword byte, or its own byte.
        assign lanes_o[8*g +: 8] =
            (size_i == SZ_BYTE) ? wdata_i[7:0] :
            (size_i == SZ_HALF) ? wdata_i[8*(g % 2) +: 8] :
                                  wdata_i[8*g +: 8];
    end

endmodule

// File: rtl/lsu_ctx_fifo.sv
// Module: in-order queue of outstanding-load context (width, fill, lane).
// Assumes the core never issues more than DEPTH loads ahead of the
// returns and never pops when empty; the top guards the pop.
module lsu_ctx_fifo #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 4,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] pop_data_o,
    output logic             empty_o
);
    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    // Next slot index with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        bump = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Slot storage written at the write pointer.
    always_ff @(posedge clk) begin
        if (push_i) begin
            slots[wr_ptr] <= push_data_i;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) wr_ptr <= bump(wr_ptr);
            if (pop_i)  rd_ptr <= bump(rd_ptr);
            if (push_i && !pop_i)      count <= count + 1'b1;
            else if (pop_i && !push_i) count <= count - 1'b1;
        end
    end

    assign pop_data_o = slots[rd_ptr];
    assign empty_o    = (count == '0);

endmodule

// File: rtl/lsu_load_extract.sv
// Module: selects the addressed byte or halfword of a read word and widens
// it with sign or zero fill. Combinational. Assumes little-endian lanes.
module lsu_load_extract
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] rdata_i,
    input  lsu_size_e         size_i,
    input  logic              zext_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [DATA_W-1:0] result_o
);
    logic [7:0]  byte_v;
    logic [15:0] half_v;
    logic        fill;

    // Lane selection by offset.
    always_comb begin
        byte_v = rdata_i[8*int'(off_i) +: 8];
        half_v = rdata_i[16*int'(off_i[OFF_W-1:1]) +: 16];
    end

    // Width extension.
    always_comb begin
        case (size_i)
            SZ_BYTE: begin
                fill     = ~zext_i & byte_v[7];
                result_o = {{(DATA_W-8){fill}}, byte_v};
            end
            SZ_HALF: begin
                fill     = ~zext_i & half_v[15];
                result_o = {{(DATA_W-16){fill}}, half_v};
            end
            default: begin
                fill     = 1'b0;
                result_o = rdata_i;
            end
        endcase
    end

endmodule

// File: rtl/lsu_align.sv
// Module: top of the load/store alignment unit. Registers one memory
// request per accepted operation, queues load context, and registers the
// extended load result. Assumes in-order read returns.
module lsu_align
    import lsu_align_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 16,
    parameter int CTX_DEPTH = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [2:0]                        req_op,
    input  logic [DATA_W-1:0]                 req_base,
    input  logic [IMM_W-1:0]                  req_imm,
    input  logic [DATA_W-1:0]                 req_wdata,
    output logic                              misalign,
    output logic                              mem_req,
    output logic                              mem_we,
    output logic [DATA_W-$clog2(DATA_W/8)-1:0] mem_addr,
    output logic [DATA_W/8-1:0]               mem_be,
    output logic [DATA_W-1:0]                 mem_wdata,
    input  logic                              mem_rvalid,
    input  logic [DATA_W-1:0]                 mem_rdata,
    output logic                              res_valid,
    output logic [DATA_W-1:0]                 res_data
);
    localparam int LANES   = DATA_W / 8;
    localparam int OFF_W   = $clog2(LANES);
    localparam int WADDR_W = DATA_W - OFF_W;
    localparam int CTX_W   = 2 + 1 + OFF_W;

    logic [DATA_W-1:0] dec_ea;
    lsu_size_e         dec_size;
    logic              dec_zext;
    logic              dec_store;
    logic              dec_mis;
    logic [LANES-1:0]  dec_be;
    logic [DATA_W-1:0] steer_data;

    logic              ctx_push;
    logic              ctx_pop;
    logic              ctx_empty;
    logic [CTX_W-1:0]  ctx_in;
    logic [CTX_W-1:0]  ctx_out;
    logic [DATA_W-1:0] ext_data;

    lsu_addr_decode #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .LANES  (LANES),
        .OFF_W  (OFF_W)
    ) u_dec (
        .op_i       (req_op),
        .base_i     (req_base),
        .imm_i      (req_imm),
        .ea_o       (dec_ea),
        .size_o     (dec_size),
        .zext_o     (dec_zext),
        .store_o    (dec_store),
        .misalign_o (dec_mis),
        .be_o       (dec_be)
    );

    lsu_store_steer #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_steer (
        .size_i  (dec_size),
        .wdata_i (req_wdata),
        .lanes_o (steer_data)
    );

    // Load context: width, fill kind and lane offset.
    assign ctx_in   = {dec_size, dec_zext, dec_ea[OFF_W-1:0]};
    assign ctx_push = req_valid && !dec_mis && !dec_store;
    assign ctx_pop  = mem_rvalid && !ctx_empty;

    lsu_ctx_fifo #(
        .WIDTH (CTX_W),
        .DEPTH (CTX_DEPTH)
    ) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (ctx_push),
        .push_data_i (ctx_in),
        .pop_i       (ctx_pop),
        .pop_data_o  (ctx_out),
        .empty_o     (ctx_empty)
    );

    lsu_load_extract #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .OFF_W  (OFF_W)
    ) u_ext (
        .rdata_i  (mem_rdata),
        .size_i   (lsu_size_e'(ctx_out[CTX_W-1 -: 2])),
        .zext_i   (ctx_out[OFF_W]),
        .off_i    (ctx_out[OFF_W-1:0]),
        .result_o (ext_data)
    );

    // Request and fault strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req  <= 1'b0;
            misalign <= 1'b0;
        end else begin
            mem_req  <= req_valid && !dec_mis;
            misalign <= req_valid && dec_mis;
        end
    end

    // Request payload, captured with each accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
        end else if (req_valid) begin
            mem_we    <= dec_store && !dec_mis;
            mem_addr  <= WADDR_W'(dec_ea[DATA_W-1:OFF_W]);
            mem_be    <= dec_be;
            mem_wdata <= steer_data;
        end
    end

    // Registered load result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= ctx_pop;
            if (ctx_pop) res_data <= ext_data;
        end
    end

endmodule

// File: rtl/lsu_align_chk.sv
// Module: port-level property checker for lsu_align, attached by bind.
module lsu_align_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             misalign,
    input logic             mem_req,
    input logic             mem_we,
    input logic [LANES-1:0] mem_be,
    input logic             mem_rvalid,
    input logic             res_valid,
    input logic             ctx_empty
);
    AST_REQ_FROM_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(req_valid)); // R1
    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                     || $countones(mem_be) == LANES)); // R2
    AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $countones(mem_be) == 2) |->
        (mem_be == LANES'(3) || mem_be == LANES'(12))); // R2
    AST_WRITE_HAS_BE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != '0)); // R2
    AST_FAULT_FROM_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> $past(req_valid)); // R7
    AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> !mem_req); // R7
    AST_RESULT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(mem_rvalid)); // R8
    AST_READ_HAS_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> !ctx_empty); // R8
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mem_req && !res_valid && !misalign)); // R9

endmodule

bind lsu_align lsu_align_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .misalign   (misalign),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .mem_rvalid (mem_rvalid),
    .res_valid  (res_valid),
    .ctx_empty  (ctx_empty)
);

// File: tb/sim_lsu_align.sv
// Bench: sweeps every operation over every byte offset of a 32-byte window
// against a byte-level shadow memory, then checks a pipelined load burst.
module sim_lsu_align;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_imm = '0;
    logic [31:0] req_wdata = '0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        misalign;
    logic        mem_req;
    logic        mem_we;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        res_valid;
    logic [31:0] res_data;

    logic [31:0] mem [8];
    logic [7:0]  shadow [32];
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    lsu_align u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
        .misalign(misalign), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .res_valid(res_valid), .res_data(res_data)
    );

    // Memory model: one-cycle read latency, byte-masked writes.
    always @(posedge clk) begin
        mem_rvalid <= rst_n && mem_req && !mem_we;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[2:0]];
        if (mem_req && mem_we)
            for (int i = 0; i < 4; i++)
                if (mem_be[i]) mem[mem_addr[2:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int op_bytes(int op);
        case (op)
            0, 3, 5: op_bytes = 1;
            1, 4, 6: op_bytes = 2;
            default: op_bytes = 4;
        endcase
    endfunction

    function automatic bit is_mis(int op, int a);
        is_mis = (op_bytes(op) == 2 && (a % 2) != 0) ||
                 (op_bytes(op) == 4 && (a % 4) != 0);
    endfunction

    function automatic logic [31:0] exp_be(int op, int a);
        exp_be = 32'(((1 << op_bytes(op)) - 1) << (a % 4));
    endfunction

    function automatic logic [31:0] exp_wdata(int op, logic [31:0] d);
        case (op)
            5:       exp_wdata = {4{d[7:0]}};
            6:       exp_wdata = {2{d[15:0]}};
            default: exp_wdata = d;
        endcase
    endfunction

    function automatic logic [31:0] ref_load(int op, int a);
        logic [15:0] h;
        case (op)
            0: ref_load = {{24{shadow[a][7]}}, shadow[a]};
            3: ref_load = {24'h0, shadow[a]};
            1: begin h = {shadow[a+1], shadow[a]}; ref_load = {{16{h[15]}}, h}; end
            4: begin h = {shadow[a+1], shadow[a]}; ref_load = {16'h0, h}; end
            default: ref_load = {shadow[a+3], shadow[a+2], shadow[a+1], shadow[a]};
        endcase
    endfunction

    function automatic string load_tag(int op);
        case (op)
            0, 1:    load_tag = "R4 signed load";
            3, 4:    load_tag = "R5 unsigned load";
            default: load_tag = "R6 word load";
        endcase
    endfunction

    // Drives one request; base/displacement pair varies, sign of imm too.
    task automatic drive(int op, int a, logic [31:0] d);
        logic [31:0] tgt;
        logic [31:0] base;
        tgt = 32'h1000 + 32'(a);
        case ((a + op) % 4)
            0:       base = 32'h0000_1000;
            1:       base = 32'h0000_1040;
            2:       base = 32'h0000_0FF0;
            default: base = 32'h0000_2000;
        endcase
        req_valid = 1'b1;
        req_op    = 3'(op);
        req_base  = base;
        req_imm   = 16'(tgt - base);
        req_wdata = d;
    endtask

    task automatic do_store(int op, int a, logic [31:0] d);
        bit mis;
        mis = is_mis(op, a);
        drive(op, a, d);
        @(posedge clk);
        @(negedge clk);
        chk("R7 misalign flag on store", 32'(misalign), 32'(mis));
        chk("R7 store request gated", 32'(mem_req), 32'(!mis));
        if (!mis) begin
            chk("R1 store word address", 32'(mem_addr), (32'h1000 + 32'(a)) >> 2);
            chk("R2 store write strobe", 32'(mem_we), 32'd1);
            chk("R2 store byte enables", 32'(mem_be), exp_be(op, a));
            chk("R3 store lane data", mem_wdata, exp_wdata(op, d));
            for (int i = 0; i < op_bytes(op); i++)
                shadow[a + i] = d[8*i +: 8];
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_load(int op, int a);
        bit mis;
        mis = is_mis(op, a);
        drive(op, a, 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 misalign flag on load", 32'(misalign), 32'(mis));
        chk("R7 load request gated", 32'(mem_req), 32'(!mis));
        if (!mis) begin
            chk("R1 load word address", 32'(mem_addr), (32'h1000 + 32'(a)) >> 2);
            chk("R2 load read strobe", 32'(mem_we), 32'd0);
            chk("R2 load byte enables", 32'(mem_be), exp_be(op, a));
        end
        req_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R8 result strobe", 32'(res_valid), 32'(!mis));
        if (!mis) chk(load_tag(op), res_data, ref_load(op, a));
        @(negedge clk);
    endtask

    initial begin
        int bo [4];
        int ba [4];
        for (int k = 0; k < 32; k++) shadow[k] = 8'(k * 53 + 8'h91);
        for (int w = 0; w < 8; w++)
            mem[w] = {shadow[4*w+3], shadow[4*w+2], shadow[4*w+1], shadow[4*w]};

        repeat (3) @(negedge clk);
        chk("R9 mem_req in reset", 32'(mem_req), 32'd0);
        chk("R9 res_valid in reset", 32'(res_valid), 32'd0);
        chk("R9 misalign in reset", 32'(misalign), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 mem_req after reset", 32'(mem_req), 32'd0);

        // Load sweep on the initial pattern.
        for (int op = 0; op < 5; op++)
            for (int a = 0; a < 32; a++) do_load(op, a);

        // Store sweep over every width and offset.
        for (int op = 5; op < 8; op++)
            for (int a = 0; a < 32; a++)
                do_store(op, a, {8'(a * 29 + op), 8'(a * 7 + 8'h83),
                                 8'(a + 8'hC0), 8'(a * 11 + op * 3 + 8'h8F)});

        // Load sweep again, now reading what the stores left behind.
        for (int op = 0; op < 5; op++)
            for (int a = 0; a < 32; a++) do_load(op, a);

        // Pipelined burst: loads on consecutive cycles return in order.
        bo = '{0, 1, 2, 4};
        ba = '{3, 6, 8, 30};
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c >= 3 && c < 7) begin
                chk("R8 burst result strobe", 32'(res_valid), 32'd1);
                chk("R8 burst result order", res_data, ref_load(bo[c-3], ba[c-3]));
            end
            if (c < 4) drive(bo[c], ba[c], 32'h0);
            else req_valid = 1'b0;
        end
        @(negedge clk);
        chk("R8 no stray result", 32'(res_valid), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule